// File: doc/BRIEF.md
# MSI Doorbell Interrupt Collector

This block gathers message-signalled interrupts for the root port of a PCIe controller and turns them into one level interrupt toward the CPU. Software programs a 64-bit doorbell address, an enable word and a mask word through a 32-bit register slave.

A downstream device signals vector v by writing the number v to the doorbell address. The block latches status bit v when that vector is enabled. It holds its interrupt line high while unmasked work is pending. Software acknowledges vectors by writing ones to the status register.

The doorbell port sees every candidate write after fabric routing. The block claims a write only when it matches the active window: a full-word write to the captured doorbell address while at least one vector is enabled. One bank of 32 vectors is covered.

Top module: `msi_doorbell_collector`

## Requirements
- R1: After reset, every register reads zero and `irq` and `db_claim` are low.
- R2: The doorbell address is read and written as two 32-bit words. A write at offset 0x820 replaces bits 31:0 only. A write at offset 0x824 replaces bits 63:32 only. Each word reads back what was written.
- R3: The enable register (offset 0x828) and the mask register (offset 0x82C) store and return all 32 bits.
- R4: A claimed doorbell write carrying value v < 32 with enable bit v set makes status bit v (offset 0x830) read 1 from the next clock edge on.
- R5: A claimed doorbell write whose enable bit is 0, or whose value is 32 or more, leaves the status register unchanged.
- R6: `db_claim` is high only when all of these hold: `db_valid` is high, `db_be` is 4'hF, `db_addr` equals the active window address, and the enable register is nonzero.
- R7: The active window address is copied from the programmed address on the clock edge where the enable register changes between zero and nonzero. Address writes made while enabled do not move the window until the next such change.
- R8: `irq` rises at the clock edge after a status bit with a zero mask bit becomes pending. Pending bits that are all masked do not raise it.
- R9: Once high, `irq` stays high while any status bit remains set, even when the pending bits are masked afterward.
- R10: Writing the status register clears each bit written as 1 and keeps the others. `irq` is low from the edge at which the status becomes zero.
- R11: When a doorbell set and a software clear of the same status bit fall in the same cycle, the bit ends set.
- R12: Offsets other than the five registers read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_off | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_off` (combinational) |
| db_valid | input | 1 | Doorbell write present |
| db_addr | input | 64 | Doorbell write address |
| db_be | input | 4 | Doorbell byte enables |
| db_data | input | 32 | Doorbell payload (vector number) |
| db_claim | output | 1 | Write decoded by this block |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
A doorbell write and a software status write can land on the same clock edge, and both may touch the same status bit. The bench drives one cycle in which the doorbell sets bit 1 while software writes a 1 to clear bit 1; it expects the bit to remain set. In a second cycle the doorbell sets bit 2 while software clears bit 1; it expects status to read exactly bit 2 and `irq` to stay high. Both outcomes are checked through a status readback on the following cycle.

// File: rtl/msi_col_pkg.sv
package msi_col_pkg;
    localparam int DW     = 32;
    localparam int AW     = 64;
    localparam int OFF_W  = 12;
    localparam int NVEC   = 32;
    localparam int VEC_W  = $clog2(NVEC);
    localparam int BE_W   = DW / 8;

    localparam logic [OFF_W-1:0] OFF_ADDR_LO = 12'h820;
    localparam logic [OFF_W-1:0] OFF_ADDR_HI = 12'h824;
    localparam logic [OFF_W-1:0] OFF_ENABLE  = 12'h828;
    localparam logic [OFF_W-1:0] OFF_MASK    = 12'h82C;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 12'h830;

    typedef struct packed {
        logic [AW-1:0]   base;   // programmed doorbell address
        logic [AW-1:0]   win;    // address actually decoded
        logic [NVEC-1:0] en;
        logic [NVEC-1:0] mask;
        logic [NVEC-1:0] stat;
        logic            irq;
    } msi_state_t;
endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
    import msi_col_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            db_valid,
    input  logic [AW-1:0]   db_addr,
    input  logic [BE_W-1:0] db_be,
    input  logic [DW-1:0]   db_data,
    input  logic [AW-1:0]   win,
    input  logic [NVEC-1:0] en,
    output logic            claim,
    output logic [NVEC-1:0] set_vec
);
    logic live;
    logic in_range;

    assign live     = (en != '0);
    assign claim    = db_valid && live && (db_be == {BE_W{1'b1}}) && (db_addr == win);
    assign in_range = (db_data < DW'(NVEC));

    for (genvar i = 0; i < NVEC; i++) begin : g_vec
        assign set_vec[i] = claim && in_range &&
                            (db_data[VEC_W-1:0] == VEC_W'(i)) && en[i];
    end

    // R6: no claim without a live decode and a full-word write
    p_claim_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (en != '0) && db_valid && (db_be == {BE_W{1'b1}}));

    // R5: at most one vector per doorbell, and only an enabled one
    p_set_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec) && ((set_vec & ~en) == '0));
endmodule

// File: rtl/msi_csr_rdmux.sv
module msi_csr_rdmux
    import msi_col_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [AW-1:0]    base,
    input  logic [NVEC-1:0]  en,
    input  logic [NVEC-1:0]  mask,
    input  logic [NVEC-1:0]  stat,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        case (off)
            OFF_ADDR_LO: rdata = base[DW-1:0];
            OFF_ADDR_HI: rdata = base[AW-1:DW];
            OFF_ENABLE:  rdata = DW'(en);
            OFF_MASK:    rdata = DW'(mask);
            OFF_STATUS:  rdata = DW'(stat);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_doorbell_collector.sv
module msi_doorbell_collector
    import msi_col_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_wr,
    input  logic [11:0]      cfg_off,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             db_valid,
    input  logic [63:0]      db_addr,
    input  logic [3:0]       db_be,
    input  logic [31:0]      db_data,
    output logic             db_claim,
    output logic             irq
);
    msi_state_t      st_d, st_q;
    logic [NVEC-1:0] set_vec;
    logic [NVEC-1:0] clr_vec;
    logic            wr;

    msi_db_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .db_valid (db_valid),
        .db_addr  (db_addr),
        .db_be    (db_be),
        .db_data  (db_data),
        .win      (st_q.win),
        .en       (st_q.en),
        .claim    (db_claim),
        .set_vec  (set_vec)
    );

    msi_csr_rdmux u_rd (
        .off   (cfg_off),
        .base  (st_q.base),
        .en    (st_q.en),
        .mask  (st_q.mask),
        .stat  (st_q.stat),
        .rdata (cfg_rdata)
    );

    assign wr = cfg_en && cfg_wr;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (wr) begin
            case (cfg_off)
                OFF_ADDR_LO: st_d.base[DW-1:0]  = cfg_wdata;
                OFF_ADDR_HI: st_d.base[AW-1:DW] = cfg_wdata;
                OFF_ENABLE:  st_d.en            = cfg_wdata[NVEC-1:0];
                OFF_MASK:    st_d.mask          = cfg_wdata[NVEC-1:0];
                OFF_STATUS:  clr_vec            = cfg_wdata[NVEC-1:0];
                default: ;
            endcase
        end
        // set has priority over a same-cycle clear
        st_d.stat = (st_q.stat & ~clr_vec) | set_vec;
        // window follows the programmed address only on a live/idle change
        if ((st_q.en == '0) != (st_d.en == '0))
            st_d.win = st_q.base;
        st_d.irq = ((st_d.stat & ~st_d.mask) != '0) ||
                   (st_q.irq && (st_d.stat != '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R4: an enabled in-range doorbell lands in status
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (db_claim && (db_data < DW'(NVEC)) && st_q.en[db_data[VEC_W-1:0]])
        |=> st_q.stat[$past(db_data[VEC_W-1:0])]);

    // R10: irq is never high with an empty status
    p_irq_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat == '0) |-> !irq);

    // R9: irq holds while anything is still pending
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (irq || (st_q.stat == '0)));

    // R7: window stays put while the decode remains live
    p_win_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.en != '0) && ($past(st_q.en) != '0)) |-> $stable(st_q.win));

    // R8: unmasked pending work always raises irq
    p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.stat & ~st_q.mask) != '0) |-> irq);
endmodule

// File: tb/sim_msi_doorbell_collector.sv
module sim_msi_doorbell_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0;
    logic [11:0] cfg_off = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        db_valid = 1'b0;
    logic [63:0] db_addr = '0;
    logic [3:0]  db_be = '0;
    logic [31:0] db_data = '0;
    logic        db_claim, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [63:0] BASE_A = 64'h0000_0001_FEE0_1000;
    localparam logic [63:0] BASE_B = 64'h0000_0001_2000_0000;

    always #4 clk = ~clk;

    msi_doorbell_collector u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .db_valid(db_valid), .db_addr(db_addr), .db_be(db_be),
        .db_data(db_data), .db_claim(db_claim), .irq(irq)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(logic [11:0] off, logic [31:0] d);
        @(negedge clk);
        cfg_en = 1; cfg_wr = 1; cfg_off = off; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 0; cfg_wr = 0;
    endtask

    task automatic reg_chk(string tag, logic [11:0] off, logic [31:0] exp);
        @(negedge clk);
        cfg_off = off;
        #1 check(tag, cfg_rdata, exp);
    endtask

    task automatic db_fire(string tag, logic [63:0] a, logic [3:0] be,
                           logic [31:0] d, logic exp_claim);
        @(negedge clk);
        db_valid = 1; db_addr = a; db_be = be; db_data = d;
        #1 check(tag, db_claim, exp_claim);
        @(negedge clk);
        db_valid = 0;
    endtask

    task automatic t_reset;
        reg_chk("R1 addr lo", 12'h820, 0);
        reg_chk("R1 addr hi", 12'h824, 0);
        reg_chk("R1 enable", 12'h828, 0);
        reg_chk("R1 mask", 12'h82C, 0);
        reg_chk("R1 status", 12'h830, 0);
        check("R1 irq", irq, 0);
        db_fire("R1 claim", 64'h0, 4'hF, 0, 0);
    endtask

    task automatic t_addr;
        reg_wr(12'h820, 32'hAAAA_0000);
        reg_wr(12'h824, 32'h0000_0001);
        reg_wr(12'h820, BASE_A[31:0]);
        reg_chk("R2 lo replaced", 12'h820, BASE_A[31:0]);
        reg_chk("R2 hi kept", 12'h824, 32'h0000_0001);
    endtask

    task automatic t_enable_mask;
        db_fire("R6 idle no claim", BASE_A, 4'hF, 3, 0);
        reg_wr(12'h82C, 32'hA5A5_5A5A);
        reg_chk("R3 mask", 12'h82C, 32'hA5A5_5A5A);
        reg_wr(12'h82C, 0);
        reg_wr(12'h828, 32'h0000_00FF);
        reg_chk("R3 enable", 12'h828, 32'h0000_00FF);
    endtask

    task automatic t_doorbell;
        db_fire("R6 claim", BASE_A, 4'hF, 3, 1);
        reg_chk("R4 status bit3", 12'h830, 32'h8);
        check("R8 irq up", irq, 1);
        db_fire("R5 disabled claimed", BASE_A, 4'hF, 12, 1);
        reg_chk("R5 disabled dropped", 12'h830, 32'h8);
        db_fire("R5 big claimed", BASE_A, 4'hF, 40, 1);
        reg_chk("R5 big dropped", 12'h830, 32'h8);
        db_fire("R6 partial be", BASE_A, 4'h3, 3, 0);
        db_fire("R6 other addr", BASE_A + 4, 4'hF, 3, 0);
    endtask

    task automatic t_window;
        reg_wr(12'h820, BASE_B[31:0]);
        db_fire("R7 old window live", BASE_A, 4'hF, 0, 1);
        db_fire("R7 new not yet", BASE_B, 4'hF, 0, 0);
        reg_wr(12'h828, 0);
        reg_wr(12'h828, 32'h0000_00FF);
        db_fire("R7 old window gone", BASE_A, 4'hF, 0, 0);
        db_fire("R7 new window live", BASE_B, 4'hF, 0, 1);
        reg_wr(12'h830, 32'h1); // drop bit0 from the window probe
        reg_chk("R10 probe cleared", 12'h830, 32'h8);
    endtask

    task automatic t_irq;
        reg_wr(12'h82C, 32'h8);
        check("R9 irq held masked", irq, 1);
        reg_wr(12'h830, 32'h8);
        reg_chk("R10 status clear", 12'h830, 0);
        check("R10 irq down", irq, 0);
        reg_wr(12'h82C, 32'h20);
        db_fire("R8 masked claim", BASE_B, 4'hF, 5, 1);
        reg_chk("R8 masked status", 12'h830, 32'h20);
        check("R8 masked no irq", irq, 0);
        reg_wr(12'h82C, 0);
        check("R8 unmask raises", irq, 1);
        db_fire("R4 second", BASE_B, 4'hF, 1, 1);
        reg_wr(12'h830, 32'h20);
        reg_chk("R10 partial", 12'h830, 32'h2);
        check("R10 irq still up", irq, 1);
    endtask

    task automatic t_collide;
        @(negedge clk);
        cfg_en = 1; cfg_wr = 1; cfg_off = 12'h830; cfg_wdata = 32'h2;
        db_valid = 1; db_addr = BASE_B; db_be = 4'hF; db_data = 1;
        @(negedge clk);
        cfg_en = 0; cfg_wr = 0; db_valid = 0;
        reg_chk("R11 set wins", 12'h830, 32'h2);
        @(negedge clk);
        cfg_en = 1; cfg_wr = 1; cfg_off = 12'h830; cfg_wdata = 32'h2;
        db_valid = 1; db_addr = BASE_B; db_be = 4'hF; db_data = 2;
        @(negedge clk);
        cfg_en = 0; cfg_wr = 0; db_valid = 0;
        reg_chk("R11 mixed", 12'h830, 32'h4);
        check("R11 irq", irq, 1);
    endtask

    task automatic t_unmapped;
        reg_wr(12'h900, 32'hFFFF_FFFF);
        reg_chk("R12 unmapped read", 12'h900, 0);
        reg_chk("R12 mask intact", 12'h82C, 0);
        reg_chk("R12 enable intact", 12'h828, 32'h0000_00FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_addr;
        t_enable_mask;
        t_doorbell;
        t_window;
        t_irq;
        t_collide;
        t_unmapped;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule